// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out where an instruction operand lives. Each request names an addressing mode, a base address register, an index data register, a 16-bit immediate/displacement field, a 32-bit absolute address field and an operand size. One cycle later the unit reports one of three results. The operand may be a literal taken from the instruction. It may be a data register to select. Or it may sit at a computed memory address, in which case a memory request is raised.

The unit holds eight 32-bit address registers. It reads index values through a combinational read port into an external data register file. In the post-increment and pre-decrement modes it steps the base register by the operand size and writes the new value back. The write-back lands on the same clock edge that registers the effective address.

Requests are single-cycle strobes with no back-pressure. A start may come every cycle, and each start yields exactly one done pulse one cycle later. A back-to-back request sees the address registers as updated by the request before it. Address registers are preloaded through a plain load port. Memory access and arithmetic on the operand belong to other units.

Top module: `opnd_ea_unit`

## Requirements
- R1: While reset is asserted and after its release, `done_o`, `mem_req_o` and `wb_en_o` are 0, and all eight address registers hold 0.
- R2: A `start_i` high in one cycle gives `done_o` high in the next cycle for exactly one cycle. Every result output is registered and changes on that same edge.
- R3: Mode 0 (immediate) gives `src_o`=0 and `imm_o` equal to `disp_i` sign-extended to 32 bits, with `mem_req_o`=0.
- R4: Mode 1 (register direct) gives `src_o`=1 and `reg_sel_o` equal to `areg_i`, with `mem_req_o`=0.
- R5: Mode 2 (memory direct) gives `src_o`=2, `mem_req_o`=1 and `mem_addr_o` equal to `abs_i`.
- R6: Mode 3 (register indirect) issues `mem_addr_o` equal to address register `areg_i`.
- R7: Mode 4 (post-increment) issues the register's current value as the address, then sets the register to that value plus the step. `size_i` 0, 1, 2 and 3 give steps of 1, 2, 4 and 4 bytes.
- R8: Mode 5 (pre-decrement) first subtracts the step from the register, then issues the decremented value as the address.
- R9: Mode 6 (displacement) issues the address register plus `disp_i`, where `disp_i` is sign-extended.
- R10: Mode 7 (indexed) issues address register `areg_i` plus data register `xreg_i` plus the sign-extended `disp_i`. `dix_sel_o` follows `xreg_i` combinationally, and `dix_val_i` is read in the start cycle.
- R11: Only modes 4 and 5 write an address register. In those modes `wb_en_o`, `wb_sel_o` and `wb_data_o` show the write-back in the done cycle. All other modes leave the registers unchanged.
- R12: All address arithmetic wraps modulo 2^32.
- R13: `ld_en_i` writes `ld_data_i` into address register `ld_sel_i` at the next edge. If an auto-modify write-back targets the same register on that edge, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code 0..7 |
| areg_i | input | 3 | Base address register / direct register number |
| xreg_i | input | 3 | Index data register number |
| disp_i | input | 16 | Immediate or displacement, signed |
| abs_i | input | 32 | Absolute address field |
| size_i | input | 2 | Operand size code |
| ld_en_i | input | 1 | Address register load enable |
| ld_sel_i | input | 3 | Address register to load |
| ld_data_i | input | 32 | Load value |
| dix_sel_o | output | 3 | Index read select to data register file |
| dix_val_i | input | 32 | Index value from data register file |
| done_o | output | 1 | Result valid pulse |
| src_o | output | 2 | Operand source: 0 literal, 1 register, 2 memory |
| imm_o | output | 32 | Literal operand value |
| reg_sel_o | output | 3 | Register direct select |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Address register write-back performed |
| wb_sel_o | output | 3 | Written address register |
| wb_data_o | output | 32 | Written value |

## Verification
Each mode gets its own directed run. Negative and positive displacements separate correct sign extension from zero extension. Post-increment runs through every size code on one register, so the issued addresses tell the step table apart from access-before-modify ordering. Pre-decrement and post-increment near the top and bottom of the address space expose arithmetic that does not wrap. Indirect reads after the displacement and indexed modes show that no stray write-back happened. A load on the same edge as a post-increment of the same register settles which write wins.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  typedef enum logic [2:0] {
    AM_LIT  = 3'd0,
    AM_DREG = 3'd1,
    AM_ABS  = 3'd2,
    AM_IND  = 3'd3,
    AM_POST = 3'd4,
    AM_PRE  = 3'd5,
    AM_DISP = 3'd6,
    AM_IDX  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SRC_LIT = 2'd0,
    SRC_REG = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  // Byte step for an operand size code
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/opnd_areg_file.sv
module opnd_areg_file #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic [AW-1:0]   ld_data,
  input  logic            wb_en,
  input  logic [SELW-1:0] wb_sel,
  input  logic [AW-1:0]   wb_data,
  input  logic [SELW-1:0] rd_sel,
  output logic [AW-1:0]   rd_data
);
  logic [NREG*AW-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [AW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= '0;
      else if (wb_en && wb_sel == SELW'(g))
        r <= wb_data;
      else if (ld_en && ld_sel == SELW'(g))
        r <= ld_data;
    end
    assign flat[g*AW +: AW] = r;
  end

  assign rd_data = flat[int'(rd_sel)*AW +: AW];
endmodule

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
  import opnd_ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DISPW = 16
) (
  input  amode_e           mode,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    index,
  input  logic [DISPW-1:0] disp,
  input  logic [AW-1:0]    abs_addr,
  input  logic [1:0]       size,
  output src_e             src,
  output logic [AW-1:0]    lit,
  output logic [AW-1:0]    ea,
  output logic             wb_req,
  output logic [AW-1:0]    new_base
);
  logic [AW-1:0] sext;
  logic [AW-1:0] step;
  logic [AW-1:0] up, down;

  assign sext = {{(AW-DISPW){disp[DISPW-1]}}, disp};
  assign step = AW'(step_bytes(size));
  assign up   = base + step;
  assign down = base - step;
  assign lit  = sext;

  always_comb begin
    src      = SRC_MEM;
    ea       = base;
    wb_req   = 1'b0;
    new_base = base;
    unique case (mode)
      AM_LIT:  begin src = SRC_LIT; ea = '0; end
      AM_DREG: begin src = SRC_REG; ea = '0; end
      AM_ABS:  ea = abs_addr;
      AM_IND:  ea = base;
      AM_POST: begin ea = base; wb_req = 1'b1; new_base = up;   end
      AM_PRE:  begin ea = down; wb_req = 1'b1; new_base = down; end
      AM_DISP: ea = base + sext;
      AM_IDX:  ea = base + index + sext;
      default: ea = base;
    endcase
  end
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
  import opnd_ea_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int DISPW = 16,
  localparam int SELW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic [SELW-1:0]  areg_i,
  input  logic [SELW-1:0]  xreg_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [AW-1:0]    abs_i,
  input  logic [1:0]       size_i,
  input  logic             ld_en_i,
  input  logic [SELW-1:0]  ld_sel_i,
  input  logic [AW-1:0]    ld_data_i,
  output logic [SELW-1:0]  dix_sel_o,
  input  logic [AW-1:0]    dix_val_i,
  output logic             done_o,
  output logic [1:0]       src_o,
  output logic [AW-1:0]    imm_o,
  output logic [SELW-1:0]  reg_sel_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             wb_en_o,
  output logic [SELW-1:0]  wb_sel_o,
  output logic [AW-1:0]    wb_data_o
);
  logic [AW-1:0] base;
  logic [AW-1:0] lit, ea, new_base;
  logic          wb_req, wb_fire;
  src_e          src;

  assign dix_sel_o = xreg_i;
  assign wb_fire   = start_i && wb_req;

  opnd_areg_file #(.NREG(NREG), .AW(AW)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en_i),
    .ld_sel  (ld_sel_i),
    .ld_data (ld_data_i),
    .wb_en   (wb_fire),
    .wb_sel  (areg_i),
    .wb_data (new_base),
    .rd_sel  (areg_i),
    .rd_data (base)
  );

  opnd_addr_calc #(.AW(AW), .DISPW(DISPW)) u_calc (
    .mode     (amode_e'(mode_i)),
    .base     (base),
    .index    (dix_val_i),
    .disp     (disp_i),
    .abs_addr (abs_i),
    .size     (size_i),
    .src      (src),
    .lit      (lit),
    .ea       (ea),
    .wb_req   (wb_req),
    .new_base (new_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      src_o      <= SRC_LIT;
      imm_o      <= '0;
      reg_sel_o  <= '0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      wb_en_o    <= 1'b0;
      wb_sel_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      done_o    <= start_i;
      mem_req_o <= start_i && (src == SRC_MEM);
      wb_en_o   <= wb_fire;
      if (start_i) begin
        src_o      <= src;
        imm_o      <= lit;
        reg_sel_o  <= areg_i;
        mem_addr_o <= ea;
        wb_sel_o   <= areg_i;
        wb_data_o  <= new_base;
      end
    end
  end
endmodule

// File: rtl/opnd_ea_chk.sv
module opnd_ea_chk
  import opnd_ea_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [2:0]  mode_i,
  input logic [2:0]  areg_i,
  input logic [1:0]  size_i,
  input logic        done_o,
  input logic [1:0]  src_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        wb_en_o,
  input logic [2:0]  wb_sel_o,
  input logic [31:0] wb_data_o
);
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));
  p_lit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && src_o == 2'd0) |-> !mem_req_o);
  p_mem_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (done_o && src_o == 2'd2));
  p_wb_only_auto_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (done_o && ($past(mode_i) == 3'd4 || $past(mode_i) == 3'd5)));
  p_auto_writes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ($past(mode_i) == 3'd4 || $past(mode_i) == 3'd5))
      |-> (wb_en_o && wb_sel_o == $past(areg_i)));
  p_post_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && $past(mode_i) == 3'd4)
      |-> (wb_data_o == mem_addr_o + 32'(step_bytes($past(size_i)))));
  p_pre_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && $past(mode_i) == 3'd5) |-> (wb_data_o == mem_addr_o));
endmodule

bind opnd_ea_unit opnd_ea_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .areg_i     (areg_i),
  .size_i     (size_i),
  .done_o     (done_o),
  .src_o      (src_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .wb_en_o    (wb_en_o),
  .wb_sel_o   (wb_sel_o),
  .wb_data_o  (wb_data_o)
);

// File: tb/opnd_ea_unit_test.sv
`timescale 1ns/1ps
module opnd_ea_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] mode_i = '0, areg_i = '0, xreg_i = '0, ld_sel_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] abs_i = '0, ld_data_i = '0;
  logic [1:0] size_i = '0;
  logic ld_en_i = 1'b0;
  logic [2:0] dix_sel_o, reg_sel_o, wb_sel_o;
  logic [31:0] dix_val_i, imm_o, mem_addr_o, wb_data_o;
  logic done_o, mem_req_o, wb_en_o;
  logic [1:0] src_o;

  logic [31:0] dreg [8];
  logic [31:0] am [8];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign dix_val_i = dreg[dix_sel_o];

  opnd_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .areg_i(areg_i), .xreg_i(xreg_i), .disp_i(disp_i), .abs_i(abs_i),
    .size_i(size_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
    .ld_data_i(ld_data_i), .dix_sel_o(dix_sel_o), .dix_val_i(dix_val_i),
    .done_o(done_o), .src_o(src_o), .imm_o(imm_o), .reg_sel_o(reg_sel_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .wb_en_o(wb_en_o),
    .wb_sel_o(wb_sel_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stp(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic load(input logic [2:0] r, input logic [31:0] v);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = r; ld_data_i = v;
    @(negedge clk);
    ld_en_i = 1'b0;
    am[r] = v;
  endtask

  // Issue one request; on return the outputs of the done cycle are visible
  task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic [2:0] x,
                       input logic [15:0] d, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    start_i = 1'b1; mode_i = m; areg_i = r; xreg_i = x;
    disp_i = d; abs_i = a; size_i = s;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done in reset", 32'(done_o), 0);
    chk("R1 mem_req in reset", 32'(mem_req_o), 0);
    chk("R1 wb_en in reset", 32'(wb_en_o), 0);
    @(negedge clk); rst_n = 1'b1;
    issue(3'd3, 3'd5, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R1 areg zero after reset", mem_addr_o, 32'h0);
  endtask

  task automatic t_lit;
    issue(3'd0, 3'd2, 3'd0, 16'hFF80, 32'h1234, 2'd0);
    chk("R2 done", 32'(done_o), 1);
    chk("R3 src literal", 32'(src_o), 0);
    chk("R3 imm sign-extended", imm_o, 32'hFFFF_FF80);
    chk("R3 no mem_req", 32'(mem_req_o), 0);
    @(negedge clk);
    chk("R2 done single pulse", 32'(done_o), 0);
  endtask

  task automatic t_dreg;
    issue(3'd1, 3'd6, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R4 src register", 32'(src_o), 1);
    chk("R4 reg_sel", 32'(reg_sel_o), 6);
    chk("R4 no mem_req", 32'(mem_req_o), 0);
  endtask

  task automatic t_abs;
    issue(3'd2, 3'd0, 3'd0, 16'h0, 32'hDEAD_BEEF, 2'd0);
    chk("R5 src memory", 32'(src_o), 2);
    chk("R5 mem_req", 32'(mem_req_o), 1);
    chk("R5 mem_addr", mem_addr_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_ind;
    load(3'd2, 32'h0000_1000);
    issue(3'd3, 3'd2, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R6 indirect addr", mem_addr_o, am[2]);
    chk("R11 no wb indirect", 32'(wb_en_o), 0);
  endtask

  task automatic t_post;
    load(3'd1, 32'h0000_0200);
    for (int s = 0; s < 4; s++) begin
      logic [31:0] old = am[1];
      issue(3'd4, 3'd1, 3'd0, 16'h0, 32'h0, 2'(s));
      am[1] = old + stp(2'(s));
      chk("R7 post addr", mem_addr_o, old);
      chk("R11 post wb_en", 32'(wb_en_o), 1);
      chk("R7 post wb_data", wb_data_o, am[1]);
    end
    issue(3'd3, 3'd1, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R7 post final reg", mem_addr_o, 32'h0000_020B);
  endtask

  task automatic t_pre;
    load(3'd4, 32'h0000_0100);
    issue(3'd5, 3'd4, 3'd0, 16'h0, 32'h0, 2'd1);
    chk("R8 pre addr", mem_addr_o, 32'h0000_00FE);
    chk("R8 pre wb sel", 32'(wb_sel_o), 4);
    issue(3'd5, 3'd4, 3'd0, 16'h0, 32'h0, 2'd2);
    chk("R8 pre back-to-back", mem_addr_o, 32'h0000_00FA);
    am[4] = 32'h0000_00FA;
  endtask

  task automatic t_disp;
    load(3'd3, 32'h0000_4000);
    issue(3'd6, 3'd3, 3'd0, 16'hFFF0, 32'h0, 2'd0);
    chk("R9 neg disp", mem_addr_o, 32'h0000_3FF0);
    chk("R11 no wb disp", 32'(wb_en_o), 0);
    issue(3'd6, 3'd3, 3'd0, 16'h0010, 32'h0, 2'd0);
    chk("R9 pos disp", mem_addr_o, 32'h0000_4010);
    issue(3'd3, 3'd3, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R11 disp left reg", mem_addr_o, 32'h0000_4000);
  endtask

  task automatic t_idx;
    load(3'd0, 32'h0000_1000);
    @(negedge clk);
    xreg_i = 3'd5;
    #1;
    chk("R10 dix_sel follows", 32'(dix_sel_o), 5);
    issue(3'd7, 3'd0, 3'd5, 16'h0008, 32'h0, 2'd0);
    chk("R10 indexed addr", mem_addr_o, 32'h0000_1038);
    issue(3'd7, 3'd0, 3'd2, 16'hFFFC, 32'h0, 2'd0);
    chk("R10 indexed neg disp", mem_addr_o, 32'h0000_1000 + dreg[2] - 32'd4);
    chk("R11 no wb indexed", 32'(wb_en_o), 0);
  endtask

  task automatic t_wrap;
    load(3'd7, 32'hFFFF_FFFE);
    issue(3'd4, 3'd7, 3'd0, 16'h0, 32'h0, 2'd1);
    chk("R12 post wrap addr", mem_addr_o, 32'hFFFF_FFFE);
    chk("R12 post wrap wb", wb_data_o, 32'h0);
    load(3'd6, 32'h0);
    issue(3'd5, 3'd6, 3'd0, 16'h0, 32'h0, 2'd1);
    chk("R12 pre wrap addr", mem_addr_o, 32'hFFFF_FFFE);
    issue(3'd6, 3'd6, 3'd0, 16'h0004, 32'h0, 2'd0);
    chk("R12 disp wrap", mem_addr_o, 32'h0000_0002);
  endtask

  task automatic t_collide;
    load(3'd5, 32'h0000_0800);
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'd4; areg_i = 3'd5; size_i = 2'd2;
    ld_en_i = 1'b1; ld_sel_i = 3'd5; ld_data_i = 32'h1111_1111;
    @(negedge clk);
    start_i = 1'b0; ld_en_i = 1'b0;
    chk("R13 collide addr", mem_addr_o, 32'h0000_0800);
    issue(3'd3, 3'd5, 3'd0, 16'h0, 32'h0, 2'd0);
    chk("R13 write-back wins", mem_addr_o, 32'h0000_0804);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      dreg[i] = 32'h10 * i + 32'h5;
      am[i] = '0;
    end
    dreg[5] = 32'h30;
    repeat (3) @(negedge clk);
    t_reset;
    t_lit;
    t_dreg;
    t_abs;
    t_ind;
    t_post;
    t_pre;
    t_disp;
    t_idx;
    t_wrap;
    t_collide;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule